// File: doc/BRIEF.md
# Maskable RTC alarm comparator

This block watches the running time-of-day of a real-time clock and decides when a programmed alarm time has arrived. It receives the current seconds, minutes, hours and day-of-month as BCD values, and four alarm settings. Each alarm setting holds a BCD compare value in its low bits and an exclude bit in its most significant bit. On every once-per-second update strobe, every field that is not excluded is compared with the matching clock field. When all of those compares succeed, a sticky alarm flag is raised. An interrupt line follows the flag, gated by an enable input.

Software clears the flag as a side effect of reading the flags register. That read arrives here as a one-cycle strobe. Excluding fields sets how often the alarm fires. With no field excluded, it fires on one particular second of one day of the month. With only the seconds field left in the compare, it fires once per minute. The seconds field is meant to stay in the compare. If it is excluded, every second of a matching minute raises the flag again.

The flag is kept by a two-state machine. `FLAG_IDLE` moves to `FLAG_RAISED` on the transition *hit*, which is an update strobe while all fields agree. `FLAG_RAISED` returns to `FLAG_IDLE` on the transition *acknowledge*, which is a flags read with no hit in the same cycle. In every other case each state holds (*wait*, *keep*).

Top module: `rtc_alarm_match`

## Requirements
- R1: A field whose alarm setting has bit 7 at 1 is left out of the compare, whatever its low seven bits and the clock field hold.
- R2: A field whose alarm setting has bit 7 at 0 takes part only when its low seven bits equal the seven-bit clock field. A single unequal included field keeps the flag from being set.
- R3: The flag becomes 1 one clock after an edge at which the update strobe is 1 and all included fields agree. Without the strobe, agreement never sets the flag.
- R4: The interrupt output is 1 exactly when the flag is 1 and the interrupt enable is 1. With the enable at 0, the flag still sets but the interrupt stays 0.
- R5: A flags-read strobe with no hit in the same cycle clears the flag on the next clock.
- R6: When a flags read and a hit occur in the same cycle, the flag is 1 afterwards.
- R7: Once set, the flag stays 1 until a read, even after the clock fields stop agreeing. While clear, it stays 0 until a hit.
- R8: After reset the flag and the interrupt are 0.
- R9: With minutes, hours and day excluded and seconds included, the flag is raised once per minute, at the programmed second only.
- R10: With the seconds field excluded, every update strobe during a matching minute raises the flag again after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_sec_i | input | 7 | Current seconds, BCD |
| cur_min_i | input | 7 | Current minutes, BCD |
| cur_hour_i | input | 7 | Current hours, BCD |
| cur_mday_i | input | 7 | Current day of month, BCD |
| alm_sec_i | input | 8 | Alarm seconds; bit 7 excludes the field |
| alm_min_i | input | 8 | Alarm minutes; bit 7 excludes the field |
| alm_hour_i | input | 8 | Alarm hours; bit 7 excludes the field |
| alm_mday_i | input | 8 | Alarm day of month; bit 7 excludes the field |
| tick_i | input | 1 | Once-per-second update strobe, one cycle wide |
| irq_en_i | input | 1 | Alarm interrupt enable |
| flag_rd_i | input | 1 | Flags-register read strobe, one cycle wide |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| irq_o | output | 1 | Alarm interrupt, level |

## Verification
The assertions assume three things about the inputs. The update and read strobes are synchronous pulses. The clock and alarm fields are stable around each strobe edge. The alarm settings change only between strobes, so a hit seen at an edge reflects settled fields. The stimulus changes fields and strobes only on the falling clock edge. Each strobe is held for exactly one cycle. Clock fields step only between ticks, as a timekeeping counter would move them.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    // Width of one alarm setting: BCD value plus an exclude bit on top.
    localparam int unsigned ALM_W    = 8;
    localparam int unsigned BCD_W    = ALM_W - 1;
    localparam int unsigned N_FIELDS = 4;

    // Field order inside the packed vectors: 0 sec, 1 min, 2 hour, 3 mday.
    typedef enum logic [1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_MDAY = 2'd3
    } field_e;

    typedef enum logic [0:0] {
        FLAG_IDLE   = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;

endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
    parameter int unsigned ALM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ALM_W-2:0] cur_i,
    input  logic [ALM_W-1:0] alm_i,
    output logic             hit_o
);
    localparam int unsigned BCD_W = ALM_W - 1;

    logic             excl;
    logic [BCD_W-1:0] want;

    assign excl = alm_i[ALM_W-1];
    assign want = alm_i[BCD_W-1:0];

    always_comb begin
        if (excl) begin
            hit_o = 1'b1;
        end else begin
            hit_o = (cur_i == want);
        end
    end

    // R1: an excluded field never blocks the compare
    p_excl_passes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        alm_i[ALM_W-1] |-> hit_o);

    // R2: an included field only agrees on an exact value
    p_included_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_i[ALM_W-1] && hit_o) |-> (cur_i == alm_i[BCD_W-1:0]));

endmodule

// File: rtl/alarm_flag_fsm.sv
module alarm_flag_fsm
    import rtc_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic all_hit_i,
    input  logic rd_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    flag_state_e state_q, state_d;
    logic        hit_ev;

    assign hit_ev = tick_i & all_hit_i;

    // Next-state logic: hit, acknowledge, wait, keep
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (hit_ev) begin
                    state_d = FLAG_RAISED;
                end
            end
            FLAG_RAISED: begin
                if (rd_i && !hit_ev) begin
                    state_d = FLAG_IDLE;
                end
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        flag_o = (state_q == FLAG_RAISED);
        irq_o  = flag_o & irq_en_i;
    end

    // R3: a hit raises the flag on the next edge
    p_hit_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && all_hit_i) |=> flag_o);

    // R3: the flag never rises without an update strobe
    p_no_set_without_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(tick_i));

    // R5: a read with no hit clears the flag
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !(tick_i && all_hit_i)) |=> !flag_o);

    // R7: with neither strobe active, the flag holds
    p_flag_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !rd_i) |=> $stable(flag_o));

    // R4: the interrupt needs both flag and enable
    p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_o && irq_en_i));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BCD_W-1:0] cur_sec_i,
    input  logic [BCD_W-1:0] cur_min_i,
    input  logic [BCD_W-1:0] cur_hour_i,
    input  logic [BCD_W-1:0] cur_mday_i,
    input  logic [ALM_W-1:0] alm_sec_i,
    input  logic [ALM_W-1:0] alm_min_i,
    input  logic [ALM_W-1:0] alm_hour_i,
    input  logic [ALM_W-1:0] alm_mday_i,
    input  logic             tick_i,
    input  logic             irq_en_i,
    input  logic             flag_rd_i,
    output logic             alarm_flag_o,
    output logic             irq_o
);
    logic [N_FIELDS-1:0][BCD_W-1:0] cur_vec;
    logic [N_FIELDS-1:0][ALM_W-1:0] alm_vec;
    logic [N_FIELDS-1:0]            hit_vec;
    logic                           all_hit;

    assign cur_vec[FLD_SEC]  = cur_sec_i;
    assign cur_vec[FLD_MIN]  = cur_min_i;
    assign cur_vec[FLD_HOUR] = cur_hour_i;
    assign cur_vec[FLD_MDAY] = cur_mday_i;
    assign alm_vec[FLD_SEC]  = alm_sec_i;
    assign alm_vec[FLD_MIN]  = alm_min_i;
    assign alm_vec[FLD_HOUR] = alm_hour_i;
    assign alm_vec[FLD_MDAY] = alm_mday_i;

    for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
        alarm_field_cmp #(.ALM_W(ALM_W)) u_cmp (
            .clk   (clk),
            .rst_n (rst_n),
            .cur_i (cur_vec[g]),
            .alm_i (alm_vec[g]),
            .hit_o (hit_vec[g])
        );
    end

    assign all_hit = &hit_vec;

    alarm_flag_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .all_hit_i (all_hit),
        .rd_i      (flag_rd_i),
        .irq_en_i  (irq_en_i),
        .flag_o    (alarm_flag_o),
        .irq_o     (irq_o)
    );

    // R6: a hit that coincides with a read leaves the flag set
    p_hit_beats_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && flag_rd_i && all_hit) |=> alarm_flag_o);

    // R4: with the enable low, the interrupt stays low
    p_irq_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> !irq_o);

endmodule

// File: tb/rtc_alarm_match_bench.sv
module rtc_alarm_match_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  flag;
        logic  irq;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] c_sec = '0, c_min = '0, c_hour = '0, c_mday = '0;
    logic [7:0] a_sec = '0, a_min = '0, a_hour = '0, a_mday = '0;
    logic       tick = 1'b0, irq_en = 1'b0, rd = 1'b0;
    logic       flag, irq;

    int   total = 0;
    int   bad = 0;
    logic model_flag = 1'b0;
    exp_t scb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_alarm_match u_rtc_alarm_match (
        .clk(clk), .rst_n(rst_n),
        .cur_sec_i(c_sec), .cur_min_i(c_min), .cur_hour_i(c_hour), .cur_mday_i(c_mday),
        .alm_sec_i(a_sec), .alm_min_i(a_min), .alm_hour_i(a_hour), .alm_mday_i(a_mday),
        .tick_i(tick), .irq_en_i(irq_en), .flag_rd_i(rd),
        .alarm_flag_o(flag), .irq_o(irq)
    );

    function automatic logic fld_ok(logic [7:0] a, logic [6:0] c);
        return a[7] || (a[6:0] == c);
    endfunction

    function automatic logic all_ok();
        return fld_ok(a_sec, c_sec) && fld_ok(a_min, c_min) &&
               fld_ok(a_hour, c_hour) && fld_ok(a_mday, c_mday);
    endfunction

    function automatic void check(logic act, logic exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
        end
    endfunction

    // Driver: one clock cycle with the given strobes; predicts the result.
    task automatic step(input logic t, input logic r, input string req);
        exp_t e;
        @(negedge clk);
        tick = t;
        rd   = r;
        if (t && all_ok())   model_flag = 1'b1;
        else if (r)          model_flag = 1'b0;
        e.flag = model_flag;
        e.irq  = model_flag & irq_en;
        e.req  = req;
        scb_q.push_back(e);
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
        rd   = 1'b0;
    endtask

    // Monitor: compares after each rising edge, clear of the edge itself.
    always @(posedge clk) begin
        #2;
        if (scb_q.size() > 0) begin
            exp_t e;
            e = scb_q.pop_front();
            check(flag, e.flag, {e.req, " flag"});
            check(irq,  e.irq,  {e.req, " irq"});
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(flag, 1'b0, "R8 reset flag");
        check(irq,  1'b0, "R8 reset irq");
        @(negedge clk);
        rst_n = 1'b1;
        irq_en = 1'b1;

        // Full match, all fields included
        c_sec = 7'h30; c_min = 7'h15; c_hour = 7'h08; c_mday = 7'h12;
        a_sec = 8'h30; a_min = 8'h15; a_hour = 8'h08; a_mday = 8'h12;
        step(0, 0, "R3 no tick no set");
        step(1, 0, "R3 tick sets");
        step(0, 0, "R7 holds set");
        c_sec = 7'h31;
        step(1, 0, "R7 holds after mismatch");
        step(0, 1, "R5 read clears");
        step(0, 0, "R7 stays clear");

        // Included mismatch on day, then exclude it
        c_sec = 7'h30;
        a_mday = 8'h13;
        step(1, 0, "R2 day mismatch blocks");
        a_mday = 8'h80 | 8'h13;
        step(1, 0, "R1 excluded day passes");
        step(0, 1, "R5 read clears");
        a_hour = 8'h80 | 8'h7f;
        c_hour = 7'h23;
        step(1, 0, "R1 excluded hour any value");
        step(0, 1, "R5 read clears");

        // Read and hit together
        step(1, 1, "R6 hit beats read");
        step(1, 1, "R6 hit beats read again");
        step(0, 1, "R5 read clears");

        // Enable gating
        irq_en = 1'b0;
        step(1, 0, "R4 enable off");
        @(negedge clk);
        irq_en = 1'b1;
        step(0, 0, "R4 enable on");
        step(0, 1, "R5 read clears");

        // Once per minute: only seconds included
        a_sec = 8'h45; a_min = 8'h80; a_hour = 8'h80; a_mday = 8'h80;
        for (int m = 0; m < 3; m++) begin
            c_min = 7'(m + 1);
            c_sec = 7'h44;
            step(1, 0, "R9 second before");
            c_sec = 7'h45;
            step(1, 0, "R9 programmed second");
            step(0, 1, "R9 read");
            c_sec = 7'h46;
            step(1, 0, "R9 second after");
        end

        // Seconds excluded: re-raise every tick of matching minute
        a_sec = 8'h80; a_min = 8'h20;
        c_min = 7'h20;
        for (int s = 0; s < 3; s++) begin
            c_sec = 7'(s);
            step(1, 0, "R10 tick in minute");
            step(0, 1, "R10 read");
        end
        c_min = 7'h21;
        step(1, 0, "R10 minute over");

        repeat (2) @(posedge clk);
        #4;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule